// File: doc/BRIEF.md
# Address-Request Auto-Response Decider

This block sits beside the control endpoint of a USB device controller. Each time a setup packet arrives, it inspects the decoded fields and the device's current state code. It then decides whether the hardware may answer the request by itself or whether the transfer must be handed to firmware. The block answers by itself only for a well-formed request to set the device address. Every other request, and every malformed address request, is flagged for software. A small code tells software why the hand-off happened.

An accepted address is not applied right away. It is held as pending until the zero-length status stage of the same transfer completes, and only then is it copied to the address output. At that point the device state output moves to "addressed" for a nonzero address, or back to "default" for address zero. A bus reset discards both the pending and the applied address. A new setup packet abandons any address still waiting for its status stage.

Top module: `setaddr_auto_resp`

## Requirements
- R1: After the synchronous active-high `rst`, `auto_ack`, `sw_req`, `err_reason`, `dev_addr` and `dev_addressed` are all 0.
- R2: A setup with `bm_request_type`=00h, `b_request`=05h, `w_index`=0, `w_length`=0, `w_value`<=7Fh and `dev_state`!=3'b011 raises `auto_ack` for one cycle, with `sw_req`=0 and `err_reason`=0 (none).
- R3: A setup whose `b_request` is not 05h goes to software with `err_reason`=1, whatever its other fields hold. This is the highest-priority reason.
- R4: Otherwise, a `bm_request_type` other than 00h gives `err_reason`=2 (not a standard host-to-device write).
- R5: Otherwise, a nonzero `w_index` gives `err_reason`=3 (request error on the index field).
- R6: Otherwise, a nonzero `w_length` gives `err_reason`=4 (not a no-data transfer).
- R7: Otherwise, a `w_value` above 7Fh gives `err_reason`=5 (request error on the value field). Exactly 7Fh is accepted.
- R8: Otherwise, `dev_state`=3'b011 (configured) gives `err_reason`=6 (device-state error).
- R9: Each `setup_valid` cycle yields, on the following cycle, exactly one single-cycle pulse: either `auto_ack` or `sw_req`. Neither pulses at any other time. `err_reason` holds its value until the next setup.
- R10: An accepted address appears on `dev_addr` only on the cycle after `status_done`. A `status_done` with no pending address leaves `dev_addr` unchanged.
- R11: Applying a nonzero address sets `dev_addressed` to 1. Applying address 0 sets it to 0.
- R12: `bus_reset` clears `dev_addr`, `dev_addressed` and any pending address. It takes precedence over a setup or `status_done` in the same cycle.
- R13: A new setup replaces or cancels any pending address. A `status_done` in the same cycle as `setup_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | One-cycle strobe: the setup fields are valid |
| bm_request_type | input | 8 | Request type byte of the setup packet |
| b_request | input | 8 | Request code byte of the setup packet |
| w_value | input | 16 | Value field of the setup packet |
| w_index | input | 16 | Index field of the setup packet |
| w_length | input | 16 | Length field of the setup packet |
| dev_state | input | 3 | Current device-state code (3'b011 = configured) |
| status_done | input | 1 | Zero-length status stage completed |
| bus_reset | input | 1 | Bus reset detected |
| auto_ack | output | 1 | Pulse: hardware answers the request |
| sw_req | output | 1 | Pulse: the transfer needs software |
| err_reason | output | 3 | Hand-off reason code, held until the next setup |
| dev_addr | output | 7 | Applied device address |
| dev_addressed | output | 1 | 1 when in addressed state, 0 when in default state |

## Verification
The decision outputs (`auto_ack`, `sw_req` and `err_reason`) are registered once. They are due on the cycle after the clock edge that sampled `setup_valid`. The applied address and the device state are due on the cycle after the edge that sampled `status_done` or `bus_reset`. The bench drives every input on a falling edge and lets one rising edge pass. It steps a reference model at that edge, then compares all five outputs on the next falling edge. This puts every check exactly one register stage after its stimulus. The idle steps that follow a decision confirm that the pulses last only one cycle and that the reason code is held.

// File: rtl/setaddr_pkg.sv
package setaddr_pkg;

    localparam int ADDR_W   = 7;
    localparam int FIELD_W  = 16;
    localparam int BYTE_W   = 8;
    localparam int STATE_W  = 3;
    localparam int REASON_W = 3;

    localparam logic [BYTE_W-1:0]  REQ_SET_ADDRESS = 8'h05;
    localparam logic [BYTE_W-1:0]  RTYPE_STD_H2D   = 8'h00;
    localparam logic [STATE_W-1:0] ST_CONFIGURED   = 3'b011;
    localparam logic [FIELD_W-1:0] ADDR_LIMIT      = FIELD_W'((1 << ADDR_W) - 1);

    // Reason codes, listed in decreasing priority
    typedef enum logic [REASON_W-1:0] {
        RSN_NONE       = 3'd0,
        RSN_OTHER_REQ  = 3'd1,
        RSN_NOT_H2D    = 3'd2,
        RSN_INDEX      = 3'd3,
        RSN_NOT_NODATA = 3'd4,
        RSN_VALUE      = 3'd5,
        RSN_STATE      = 3'd6
    } reason_e;

    typedef struct packed {
        logic [BYTE_W-1:0]  req_type;
        logic [BYTE_W-1:0]  req_code;
        logic [FIELD_W-1:0] value;
        logic [FIELD_W-1:0] index;
        logic [FIELD_W-1:0] length;
    } setup_t;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    typedef enum logic {
        AST_DEFAULT   = 1'b0,
        AST_ADDRESSED = 1'b1
    } addr_state_e;

    function automatic verdict_t judge(setup_t s, logic [STATE_W-1:0] st);
        verdict_t v;
        v.accept = 1'b0;
        if (s.req_code != REQ_SET_ADDRESS)   v.reason = RSN_OTHER_REQ;
        else if (s.req_type != RTYPE_STD_H2D) v.reason = RSN_NOT_H2D;
        else if (s.index != '0)              v.reason = RSN_INDEX;
        else if (s.length != '0)             v.reason = RSN_NOT_NODATA;
        else if (s.value > ADDR_LIMIT)       v.reason = RSN_VALUE;
        else if (st == ST_CONFIGURED)        v.reason = RSN_STATE;
        else begin
            v.reason = RSN_NONE;
            v.accept = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/setaddr_classify.sv
module setaddr_classify
    import setaddr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               setup_valid,
    input  setup_t             pkt,
    input  logic [STATE_W-1:0] state_code,
    output verdict_t           verdict_now,
    output logic               auto_q,
    output logic               sw_q,
    output reason_e            reason_q
);

    always_comb verdict_now = judge(pkt, state_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q   <= 1'b0;
            sw_q     <= 1'b0;
            reason_q <= RSN_NONE;
        end else begin
            auto_q <= setup_valid &  verdict_now.accept;
            sw_q   <= setup_valid & ~verdict_now.accept;
            if (setup_valid) reason_q <= verdict_now.reason;
        end
    end

endmodule

// File: rtl/setaddr_commit.sv
module setaddr_commit
    import setaddr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          setup_valid,
    input  logic          accept,
    input  logic [AW-1:0] new_addr,
    input  logic          status_done,
    output logic [AW-1:0] addr_q,
    output logic          addressed
);

    logic          pend_q;
    logic [AW-1:0] pend_addr_q;
    addr_state_e   ast_q;

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            addr_q      <= '0;
            ast_q       <= AST_DEFAULT;
        end else if (setup_valid) begin
            // a new setup abandons any earlier transfer
            pend_q      <= accept;
            pend_addr_q <= new_addr;
        end else if (status_done && pend_q) begin
            pend_q <= 1'b0;
            addr_q <= pend_addr_q;
            ast_q  <= (pend_addr_q != '0) ? AST_ADDRESSED : AST_DEFAULT;
        end
    end

    assign addressed = (ast_q == AST_ADDRESSED);

endmodule

// File: rtl/setaddr_auto_resp.sv
module setaddr_auto_resp
    import setaddr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                setup_valid,
    input  logic [BYTE_W-1:0]   bm_request_type,
    input  logic [BYTE_W-1:0]   b_request,
    input  logic [FIELD_W-1:0]  w_value,
    input  logic [FIELD_W-1:0]  w_index,
    input  logic [FIELD_W-1:0]  w_length,
    input  logic [STATE_W-1:0]  dev_state,
    input  logic                status_done,
    input  logic                bus_reset,
    output logic                auto_ack,
    output logic                sw_req,
    output logic [REASON_W-1:0] err_reason,
    output logic [ADDR_W-1:0]   dev_addr,
    output logic                dev_addressed
);

    setup_t   pkt;
    verdict_t verdict;
    reason_e  reason_q;

    always_comb begin
        pkt.req_type = bm_request_type;
        pkt.req_code = b_request;
        pkt.value    = w_value;
        pkt.index    = w_index;
        pkt.length   = w_length;
    end

    setaddr_classify u_classify (
        .clk         (clk),
        .rst         (rst),
        .setup_valid (setup_valid),
        .pkt         (pkt),
        .state_code  (dev_state),
        .verdict_now (verdict),
        .auto_q      (auto_ack),
        .sw_q        (sw_req),
        .reason_q    (reason_q)
    );

    assign err_reason = reason_q;

    setaddr_commit #(.AW(ADDR_W)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset),
        .setup_valid (setup_valid),
        .accept      (verdict.accept),
        .new_addr    (w_value[ADDR_W-1:0]),
        .status_done (status_done),
        .addr_q      (dev_addr),
        .addressed   (dev_addressed)
    );

endmodule

// File: rtl/setaddr_chk.sv
module setaddr_chk
    import setaddr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                setup_valid,
    input logic [BYTE_W-1:0]   bm_request_type,
    input logic [BYTE_W-1:0]   b_request,
    input logic [FIELD_W-1:0]  w_value,
    input logic [FIELD_W-1:0]  w_index,
    input logic [FIELD_W-1:0]  w_length,
    input logic [STATE_W-1:0]  dev_state,
    input logic                status_done,
    input logic                bus_reset,
    input logic                auto_ack,
    input logic                sw_req,
    input logic [REASON_W-1:0] err_reason,
    input logic [ADDR_W-1:0]   dev_addr,
    input logic                dev_addressed
);

    // counts clean cycles since reset so $past never reaches before it
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        setup_valid |=> (auto_ack ^ sw_req));

    assert_no_stray_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && (auto_ack || sw_req)) |-> $past(setup_valid));

    assert_auto_no_reason_R2: assert property (@(posedge clk) disable iff (rst)
        auto_ack |-> (err_reason == 3'd0));

    assert_other_req_first_R3: assert property (@(posedge clk) disable iff (rst)
        (setup_valid && b_request != 8'h05) |=> (sw_req && err_reason == 3'd1));

    assert_configured_state_R8: assert property (@(posedge clk) disable iff (rst)
        (setup_valid && b_request == 8'h05 && bm_request_type == 8'h00 &&
         w_index == 16'h0 && w_length == 16'h0 && w_value <= 16'h7F &&
         dev_state == 3'b011) |=> (sw_req && err_reason == 3'd6));

    assert_addr_only_on_commit_R10: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && !$past(status_done) && !$past(bus_reset)) |-> $stable(dev_addr));

    assert_state_tracks_addr_R11: assert property (@(posedge clk) disable iff (rst)
        dev_addressed == (dev_addr != '0));

    assert_bus_reset_clears_R12: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (dev_addr == '0 && !dev_addressed));

endmodule

bind setaddr_auto_resp setaddr_chk u_chk (.*);

// File: tb/tb_setaddr_auto_resp.sv
module tb_setaddr_auto_resp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        setup_valid = 1'b0;
    logic [7:0]  bm_request_type = '0;
    logic [7:0]  b_request = '0;
    logic [15:0] w_value = '0;
    logic [15:0] w_index = '0;
    logic [15:0] w_length = '0;
    logic [2:0]  dev_state = '0;
    logic        status_done = 1'b0;
    logic        bus_reset = 1'b0;
    logic        auto_ack;
    logic        sw_req;
    logic [2:0]  err_reason;
    logic [6:0]  dev_addr;
    logic        dev_addressed;

    int checks = 0;
    int failures = 0;

    // reference state
    logic       m_auto, m_sw, m_pend, m_addressed;
    logic [2:0] m_reason;
    logic [6:0] m_addr, m_paddr;

    setaddr_auto_resp dut (
        .clk(clk), .rst(rst), .setup_valid(setup_valid),
        .bm_request_type(bm_request_type), .b_request(b_request),
        .w_value(w_value), .w_index(w_index), .w_length(w_length),
        .dev_state(dev_state), .status_done(status_done), .bus_reset(bus_reset),
        .auto_ack(auto_ack), .sw_req(sw_req), .err_reason(err_reason),
        .dev_addr(dev_addr), .dev_addressed(dev_addressed)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] ref_reason(logic [7:0] rt, logic [7:0] rq,
            logic [15:0] v, logic [15:0] ix, logic [15:0] ln, logic [2:0] st);
        if (rq != 8'h05)      return 3'd1;
        if (rt != 8'h00)      return 3'd2;
        if (ix != 16'h0)      return 3'd3;
        if (ln != 16'h0)      return 3'd4;
        if (v > 16'h007F)     return 3'd5;
        if (st == 3'b011)     return 3'd6;
        return 3'd0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_auto = 0; m_sw = 0; m_reason = 0;
        m_addr = 0; m_addressed = 0; m_pend = 0; m_paddr = 0;
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(string tag, logic sv, logic [7:0] rt, logic [7:0] rq,
            logic [15:0] v, logic [15:0] ix, logic [15:0] ln, logic [2:0] st,
            logic sd, logic br);
        logic [2:0] r;
        setup_valid = sv; bm_request_type = rt; b_request = rq;
        w_value = v; w_index = ix; w_length = ln; dev_state = st;
        status_done = sd; bus_reset = br;
        @(posedge clk);
        #1;
        r = ref_reason(rt, rq, v, ix, ln, st);
        m_auto = sv && (r == 3'd0);
        m_sw   = sv && (r != 3'd0);
        if (sv) m_reason = r;
        if (br) begin
            m_addr = 0; m_addressed = 0; m_pend = 0;
        end else if (sv) begin
            m_pend = (r == 3'd0); m_paddr = v[6:0];
        end else if (sd && m_pend) begin
            m_addr = m_paddr; m_addressed = (m_paddr != 0); m_pend = 0;
        end
        @(negedge clk);
        chk(tag, "auto_ack", auto_ack, m_auto);
        chk(tag, "sw_req", sw_req, m_sw);
        chk(tag, "err_reason", err_reason, m_reason);
        chk(tag, "dev_addr", dev_addr, m_addr);
        chk(tag, "dev_addressed", dev_addressed, m_addressed);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 3'b010, 0, 0);
    endtask

    task automatic setad(string tag, logic [15:0] v, logic [2:0] st);
        step(tag, 1, 8'h00, 8'h05, v, 16'h0, 16'h0, st, 0, 0);
    endtask

    task automatic commit(string tag);
        step(tag, 0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 3'b010, 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk("R1", "auto_ack", auto_ack, 0);
        chk("R1", "sw_req", sw_req, 0);
        chk("R1", "err_reason", err_reason, 0);
        chk("R1", "dev_addr", dev_addr, 0);
        chk("R1", "dev_addressed", dev_addressed, 0);

        // R2 accept; R10 address not yet applied
        setad("R2", 16'h0012, 3'b010);
        idle("R9");
        idle("R10");
        commit("R10");
        chk("R11", "addressed after commit", dev_addressed, 1);
        commit("R10");                          // nothing pending: no effect

        // R3 other request wins over every other fault
        step("R3", 1, 8'h80, 8'h06, 16'h0100, 16'h0, 16'h0012, 3'b011, 0, 0);
        step("R3", 1, 8'h21, 8'h09, 16'h0FFF, 16'h1, 16'h1, 3'b010, 0, 0);
        // R4
        step("R4", 1, 8'h80, 8'h05, 16'h0010, 16'h0, 16'h0, 3'b010, 0, 0);
        // R5
        step("R5", 1, 8'h00, 8'h05, 16'h0010, 16'h0001, 16'h0001, 3'b010, 0, 0);
        // R6
        step("R6", 1, 8'h00, 8'h05, 16'h0010, 16'h0, 16'h0002, 3'b010, 0, 0);
        // R7 boundary
        setad("R7", 16'h007F, 3'b001);
        setad("R7", 16'h0080, 3'b001);
        // R8 configured state vs addressed state
        setad("R8", 16'h0020, 3'b011);
        setad("R8", 16'h0020, 3'b010);
        idle("R9");                             // reason held, pulses gone
        commit("R10");
        // R11 address zero returns to default
        setad("R11", 16'h0000, 3'b010);
        commit("R11");
        // R12 bus reset clears applied and pending
        setad("R12", 16'h0033, 3'b001);
        commit("R12");
        setad("R12", 16'h0044, 3'b010);
        step("R12", 0, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 3'b010, 1, 1);
        commit("R12");
        setad("R12", 16'h0055, 3'b000);
        step("R12", 1, 8'h00, 8'h05, 16'h0066, 16'h0, 16'h0, 3'b000, 0, 1);
        commit("R12");
        // R13 a new setup replaces / cancels pending
        setad("R13", 16'h0011, 3'b000);
        setad("R13", 16'h0022, 3'b000);
        commit("R13");
        setad("R13", 16'h0033, 3'b010);
        step("R13", 1, 8'h00, 8'h08, 16'h0, 16'h0, 16'h1, 3'b010, 0, 0);
        commit("R13");
        setad("R13", 16'h0044, 3'b010);
        step("R13", 1, 8'h00, 8'h05, 16'h0055, 16'h0, 16'h0, 3'b010, 1, 0);
        idle("R13");
        commit("R13");

        // constrained random mix
        seed_val = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 800; i++) begin
            int unsigned k = $urandom % 16;
            logic [7:0]  rt = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
            logic [7:0]  rq = ($urandom % 6 == 0) ? 8'($urandom % 16) : 8'h05;
            logic [15:0] v  = ($urandom % 6 == 0) ? 16'($urandom) : 16'($urandom % 128);
            logic [15:0] ix = ($urandom % 8 == 0) ? 16'($urandom % 4) : 16'h0;
            logic [15:0] ln = ($urandom % 8 == 0) ? 16'($urandom % 64) : 16'h0;
            logic [2:0]  st = 3'($urandom);
            if (k < 6)       step("R9", 1, rt, rq, v, ix, ln, st, ($urandom % 4 == 0), 0);
            else if (k < 11) commit("R10");
            else if (k == 11) step("R12", ($urandom % 2 == 1), rt, rq, v, ix, ln, st, 1, 1);
            else             idle("R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule